// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block holds the digital side of an 8-bit successive-approximation converter. A host starts a conversion by pulling the active-low chip select and write strobe low together. The block divides its clock by eight to make the stepping rate. It then walks a single marker bit through an 8-stage shift register and tests one result bit per step, MSB first.

The block drives the trial code to an external DAC and reads back one digital comparator decision per step. When the marker leaves the last stage, it copies the word into output latches and pulls the active-low interrupt low. The host reads the word by pulling chip select and read low, which drives the tri-state data bus; at all other times the bus floats.

The start logic accepts a start pulse of any width. While chip select and write are both held low, the sequencer stays cleared, and stepping begins only after one of them is released. For a free-running converter, the interrupt is wired to the write input with chip select held low. Each completion then restarts the block, and the interrupt shrinks to a short pulse. All strobes pass through a two-flop synchronizer, and everything runs on the single external clock.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `trial` is 0, and a read returns 0 on `db`.
- R2: While `cs_n` and `wr_n` are both low (after synchronization), `trial` stays 0 and `intr_n` stays high, however long the hold lasts.
- R3: `intr_n` falls exactly 74 clocks after the start request is released (2 synchronizer stages plus 9 internal ticks of 8 clocks each).
- R4: The first trial code, driven on the 10th clock after release, is 0x80. Each later step keeps the tested bit when `cmp_ge` is 1 (input at or above the trial) and clears it otherwise, then sets the next lower bit. The final word equals the input level, with `db[7]` as MSB and `db[0]` as LSB.
- R5: `trial` changes only on an internal tick (one clock in eight) or on a start request.
- R6: With `cs_n` and `rd_n` both low, `db` carries the last completed result from the third clock after the strobes fall; otherwise it is high impedance.
- R7: After a normal completion, `intr_n` stays low until a read, and the read returns it high.
- R8: If `cs_n` and `rd_n` are held low through completion, `intr_n` still falls and stays low for exactly 8 clocks.
- R9: With `intr_n` fed back to `wr_n` and `cs_n` held low, each interrupt pulse lasts 3 clocks, and successive falling edges are 77 clocks apart.
- R10: A start request during a conversion aborts it and restarts from the MSB, again taking 74 clocks from release. Until the new result is ready, the output latches keep the last completed result.
- R11: A low `wr_n` while `cs_n` is high starts nothing: `intr_n` stays high and the latched result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe, starts a conversion (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| cmp_ge | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| trial | output | 8 | Trial code driven to the DAC |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |
| db | inout | 8 | Tri-state result bus, bit 7 is the MSB |

## Verification
A wrong marker position or a wrong step decision shows up as a wrong word on `db` at the next read. A drifting divider shows up as a completion that lands off the exact 74-clock mark. A start flag that fails to hold while the strobe is low shows up within one internal tick, as a 0x80 on `trial` during the hold. Faults in the interrupt logic change the pulse width in three places: held-read mode (8 clocks), free-running mode (3 clocks) and normal mode (until a read). Each of these is measured to the exact clock.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Host strobe bundle, all active low; synchronized together.
  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_tick.sv
module sar_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST) && !hold;
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic            tick,
  input  logic            cmp_ge,
  output logic [BITS-1:0] trial,
  output logic            busy,
  output logic            fin,
  output logic [BITS-1:0] word
);
  localparam logic [BITS-1:0] TOP_BIT = {1'b1, {(BITS-1){1'b0}}};

  logic            armed_q;
  logic            busy_q;
  logic [BITS-1:0] marker_q;
  logic [BITS-1:0] sar_q;
  logic [BITS-1:0] sar_nxt;

  // Resolve the bit under test, then raise the next lower trial bit.
  always_comb begin
    sar_nxt = (sar_q & ~marker_q)
            | (cmp_ge ? marker_q : '0)
            | (marker_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      busy_q   <= 1'b0;
      marker_q <= '0;
      sar_q    <= '0;
    end else if (start_req) begin
      armed_q  <= 1'b1;
      busy_q   <= 1'b0;
      marker_q <= '0;
      sar_q    <= '0;
    end else if (tick) begin
      if (armed_q) begin
        armed_q  <= 1'b0;
        busy_q   <= 1'b1;
        marker_q <= TOP_BIT;
        sar_q    <= TOP_BIT;
      end else if (busy_q) begin
        sar_q    <= sar_nxt;
        marker_q <= marker_q >> 1;
        if (marker_q[0]) busy_q <= 1'b0;
      end
    end
  end

  assign trial = sar_q;
  assign busy  = busy_q;
  assign fin   = tick && busy_q && marker_q[0] && !start_req;
  assign word  = sar_nxt;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int BITS = 8,
  parameter int DIV  = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            cmp_ge,
  output logic [BITS-1:0] trial,
  output logic            intr_n,
  inout  wire  [BITS-1:0] db
);
  import sar_pkg::*;

  localparam int EW = $clog2(DIV + 1);
  localparam logic [EW-1:0] WIN = EW'(DIV);

  strobe_t         raw, syn;
  logic            start_req, rd_act, tick, busy, fin;
  logic [BITS-1:0] word;
  logic [BITS-1:0] out_q;
  logic            intr_flag_q;
  logic [EW-1:0]   eoc_cnt;

  assign raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n};

  sar_sync #(.W(STROBE_W), .STAGES(SYNC), .RST_VAL('1)) i_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign start_req = !syn.cs_n && !syn.wr_n;
  assign rd_act    = !syn.cs_n && !syn.rd_n;

  sar_tick #(.DIV(DIV)) i_tick (
    .clk(clk), .rst(rst), .hold(start_req), .tick(tick)
  );

  sar_engine #(.BITS(BITS)) i_eng (
    .clk(clk), .rst(rst), .start_req(start_req), .tick(tick),
    .cmp_ge(cmp_ge), .trial(trial), .busy(busy), .fin(fin), .word(word)
  );

  // Output latches, interrupt flag and the one-tick set window.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q       <= '0;
      intr_flag_q <= 1'b0;
      eoc_cnt     <= '0;
    end else if (start_req) begin
      intr_flag_q <= 1'b0;
      eoc_cnt     <= '0;
    end else if (fin) begin
      out_q       <= word;
      eoc_cnt     <= WIN;
      intr_flag_q <= !rd_act;
    end else begin
      if (eoc_cnt != '0) eoc_cnt     <= eoc_cnt - 1'b1;
      if (rd_act)        intr_flag_q <= 1'b0;
    end
  end

  assign intr_n = !(intr_flag_q || (eoc_cnt != '0));
  assign db     = rd_act ? out_q : {BITS{1'bz}};
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int BITS = 8,
  parameter int EW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start_req,
  input logic            rd_act,
  input logic            tick,
  input logic            fin,
  input logic            busy,
  input logic [EW-1:0]   eoc_cnt,
  input logic            intr_n,
  input logic [BITS-1:0] trial
);
  assert_hold_clears_trial_R2: assert property (@(posedge clk) disable iff (rst)
    start_req |=> (trial == '0));

  assert_trial_moves_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start_req) |=> $stable(trial));

  assert_fin_drops_intr_R3: assert property (@(posedge clk) disable iff (rst)
    fin |=> !intr_n);

  assert_read_clears_intr_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_act && !fin && (eoc_cnt <= EW'(1))) |=> intr_n);

  assert_intr_window_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(intr_n) && !start_req) |=> !intr_n);

  assert_start_aborts_R10: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !busy);
endmodule

bind sar_ctrl sar_ctrl_chk #(.BITS(BITS), .EW(EW)) i_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .rd_act(rd_act),
  .tick(tick), .fin(fin), .busy(busy), .eoc_cnt(eoc_cnt),
  .intr_n(intr_n), .trial(trial)
);

// File: tb/test_sar_ctrl.sv
`timescale 1ns/1ps
module test_sar_ctrl;
  localparam int BITS = 8;
  localparam int LAT  = 74;
  localparam int NVEC = 8;
  localparam logic [7:0] LEVELS [NVEC] = '{8'h00, 8'hFF, 8'h80, 8'h7F,
                                           8'h55, 8'hAA, 8'h01, 8'hC3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, free = 1'b0;
  logic [7:0] vin = 8'h00;
  logic [BITS-1:0] trial;
  logic intr_n, cmp_ge, wr_n;
  wire  [BITS-1:0] db;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  assign cmp_ge = (vin >= trial);
  assign wr_n   = free ? (intr_n & wr_drv) : wr_drv;

  sar_ctrl i_sar_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_ge(cmp_ge), .trial(trial), .intr_n(intr_n), .db(db)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_pulse(input bit keep_cs);
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    idle(4);
    wr_drv = 1'b1;
    if (!keep_cs) cs_n = 1'b1;
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (intr_n !== 1'b0 && n < 300) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); v = db;
    cs_n = 1'b1; rd_n = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, lowc, p;
    logic [7:0] v;
    idle(3); rst = 1'b0; idle(3);

    // R1 reset state
    chk("R1 intr_n", int'(intr_n), 1);
    chk("R1 trial", int'(trial), 0);
    do_read(v); chk("R1 db", int'(v), 0);

    // Vector table: level -> latency, held interrupt, result, read clear
    foreach (LEVELS[i]) begin
      vin = LEVELS[i];
      start_pulse(1'b0);
      wait_fall(n);
      chk("R3 latency", n, LAT);
      idle(12);
      chk("R7 intr held until read", int'(intr_n), 0);
      do_read(v);
      chk("R4 R6 result", int'(v), int'(LEVELS[i]));
      idle(10);
      chk("R7 intr cleared by read", int'(intr_n), 1);
    end

    // R2 long hold, then R4 first trial and R5 tick spacing
    vin = 8'h96;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    idle(4);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (trial !== 8'h00 || intr_n !== 1'b1) begin
        chk("R2 held start", int'({intr_n, trial}), int'({1'b1, 8'h00}));
      end
    end
    chk("R2 trial during hold", int'(trial), 0);
    wr_drv = 1'b1; cs_n = 1'b1;
    repeat (9) @(posedge clk); @(negedge clk);
    chk("R4 trial before launch", int'(trial), 0);
    @(posedge clk); @(negedge clk);
    chk("R4 first trial", int'(trial), 8'h80);
    repeat (7) @(posedge clk); @(negedge clk);
    chk("R5 trial stable within tick", int'(trial), 8'h80);
    @(posedge clk); @(negedge clk);
    chk("R4 second trial", int'(trial), 8'hC0);
    wait_fall(n);
    chk("R2 latency after release", n + 18, LAT);
    do_read(v); chk("R2 result", int'(v), 8'h96);

    // R11 write without chip select
    vin = 8'h11;
    @(negedge clk); wr_drv = 1'b0; idle(20); wr_drv = 1'b1;
    lowc = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); if (intr_n !== 1'b1) lowc++;
    end
    chk("R11 no interrupt", lowc, 0);
    do_read(v); chk("R11 result kept", int'(v), 8'h96);

    // R10 abort mid-conversion
    vin = 8'h3C;
    start_pulse(1'b0); wait_fall(n); do_read(v);
    chk("R10 first result", int'(v), 8'h3C);
    vin = 8'hD2;
    start_pulse(1'b0); idle(30);
    do_read(v); chk("R10 latches keep old", int'(v), 8'h3C);
    start_pulse(1'b0); wait_fall(n);
    chk("R10 restart latency", n, LAT);
    do_read(v); chk("R10 new result", int'(v), 8'hD2);

    // R8 continuous read
    vin = 8'h5A;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    start_pulse(1'b1);
    wait_fall(n);
    chk("R8 latency", n, LAT);
    lowc = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); if (intr_n === 1'b0) lowc++;
    end
    chk("R8 pulse width", lowc, 8);
    chk("R8 bus value", int'(db), 8'h5A);
    cs_n = 1'b1; rd_n = 1'b1; idle(4);

    // R9 free-running
    vin = 8'hE7;
    @(negedge clk); cs_n = 1'b0; free = 1'b1; wr_drv = 1'b0;
    idle(4); wr_drv = 1'b1;
    wait_fall(n);
    chk("R9 first latency", n, LAT);
    lowc = 1; p = 0;
    while (intr_n === 1'b0 && p < 300) begin
      @(posedge clk); p++; @(negedge clk);
      if (intr_n === 1'b0) lowc++;
    end
    while (intr_n !== 1'b0 && p < 300) begin
      @(posedge clk); p++; @(negedge clk);
    end
    chk("R9 pulse width", lowc, 3);
    chk("R9 period", p, 77);
    free = 1'b0; cs_n = 1'b1;
    idle(100);
    do_read(v); chk("R9 free-run result", int'(v), 8'hE7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule